// File: doc/BRIEF.md
# Prioritized ADC Sample Sequencer Controller

This controller lets four independently programmed sample sequences share one analog-to-digital converter. Each sequence has an enable bit and a selectable trigger source. It also has a list of up to eight steps, and each step carries a channel select and a control nibble. A trigger on an enabled sequence is latched as pending. Whenever the converter is idle, a priority table decides which pending sequence owns the converter next.

The owning sequence runs its steps in order. For each step it drives the channel select, pulses a conversion start and waits for the converter's done strobe. It then presents the result together with the sequence and step numbers. A step can mark the end of its sequence, and a step can request an interrupt. Raw interrupt bits are set by those steps, cleared by writing ones, and gated onto the interrupt outputs by a mask. All configuration goes through a small word-wide register port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, enable (0x00), raw status (0x04) and mask (0x08) read 0, the priority register (0x14) reads 0xE4, and irq and conv_start are 0.
- R2: A sequencer whose enable bit (bit i of 0x00) is 0 ignores its trigger, and enabling it later does not start a run from that earlier trigger.
- R3: The priority register at 0x14 holds a 2-bit value for sequencer i in bits 2i+1:2i. Among pending, enabled sequencers the lowest value is granted first, and a tie goes to the lower index.
- R4: A granted sequencer runs its steps from 0 upward. For step k it drives conv_chan from bits 4k+3:4k of its channel register (0x20+8i) and gives exactly one single-cycle conv_start. It stops after the step whose control nibble (bits 4k+3:4k of 0x24+8i) has bit 1 (END) set.
- R5: If no step of a sequence has END set, the run ends after step 7, giving exactly eight conversions.
- R6: A running sequence is never preempted. All of its results appear before those of any other sequencer, even one of higher priority that is triggered during the run.
- R7: Completing a step whose control nibble has bit 2 (IE) set sets raw status bit i at 0x04. Writing 1 to that bit clears it.
- R8: irq[i] is raw bit i AND mask bit i (mask at 0x08), so a raw bit with its mask at 0 never reaches irq.
- R9: One cycle after conv_done, res_valid pulses for one cycle with res_data equal to conv_data, res_seq the sequencer, and res_step the step.
- R10: The trigger source of sequencer i is the evt_in bit selected by bits 4i+3:4i of 0x10. A pulse on any other evt_in bit does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| evt_in | input | NEVT | Trigger event inputs, active high |
| conv_start | output | 1 | Conversion start pulse |
| conv_chan | output | CHW | Channel select for the current step |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | DW | Converter result |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | DW | Result value |
| res_seq | output | 2 | Sequencer that produced the result |
| res_step | output | SW | Step that produced the result |
| irq | output | 4 | Masked interrupt per sequencer |

## Verification
The assertions rely on the converter answering each conv_start with exactly one conv_done, and never raising conv_done while no conversion is outstanding. The bench's converter model keeps to this. It samples conv_start and returns a single done strobe two cycles later, carrying the channel in the low data bits. Register writes and event pulses are applied only between clock edges, and each pulse lasts one cycle. A new scenario starts only after the previous runs have drained.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NSTEP = 8,
  parameter int CHW   = 4,
  parameter int DW    = 12,
  parameter int NEVT  = 16,
  localparam int SW   = $clog2(NSTEP),
  localparam int EW   = $clog2(NEVT),
  localparam int MW   = NSTEP * CHW,
  localparam int CW   = NSTEP * 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NEVT-1:0] evt_in,
  output logic            conv_start,
  output logic [CHW-1:0]  conv_chan,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  output logic            res_valid,
  output logic [DW-1:0]   res_data,
  output logic [1:0]      res_seq,
  output logic [SW-1:0]   res_step,
  output logic [3:0]      irq
);
  typedef enum logic [1:0] {IDLE, START, WAIT} st_t;

  st_t            st;
  logic [3:0]     en, mask, raw, pend, hit;
  logic [7:0]     prio;
  logic [4*EW-1:0] emux;
  logic [MW-1:0]  smux [4];
  logic [CW-1:0]  sctl [4];
  logic [1:0]     cur, gnt, bp;
  logic [SW-1:0]  step;
  logic           gnt_v, grant, done_ok, last;
  logic [3:0]     cnib;

  assign cnib       = sctl[cur][4*step +: 4];
  assign conv_chan  = smux[cur][CHW*step +: CHW];
  assign conv_start = (st == START);
  assign grant      = (st == IDLE) && gnt_v;
  assign done_ok    = (st == WAIT) && conv_done;
  assign last       = cnib[1] || (step == SW'(NSTEP-1));
  assign irq        = raw & mask;

  always_comb begin
    for (int i = 0; i < 4; i++) hit[i] = en[i] && evt_in[emux[EW*i +: EW]];
  end

  always_comb begin
    gnt_v = 1'b0;
    gnt   = 2'd0;
    bp    = 2'd3;
    for (int i = 0; i < 4; i++) begin
      if (en[i] && pend[i] && (!gnt_v || prio[2*i +: 2] < bp)) begin
        gnt_v = 1'b1;
        gnt   = 2'(i);
        bp    = prio[2*i +: 2];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      8'h00:   reg_rdata = 32'(en);
      8'h04:   reg_rdata = 32'(raw);
      8'h08:   reg_rdata = 32'(mask);
      8'h0C:   reg_rdata = 32'(irq);
      8'h10:   reg_rdata = 32'(emux);
      8'h14:   reg_rdata = 32'(prio);
      default: reg_rdata = 32'd0;
    endcase
    for (int i = 0; i < 4; i++) begin
      if (reg_addr == 8'(8'h20 + 8*i)) reg_rdata = 32'(smux[i]);
      if (reg_addr == 8'(8'h24 + 8*i)) reg_rdata = 32'(sctl[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      mask <= '0;
      raw  <= '0;
      pend <= '0;
      prio <= 8'hE4;
      emux <= '0;
      for (int i = 0; i < 4; i++) begin
        smux[i] <= '0;
        sctl[i] <= '0;
      end
    end else begin
      if (reg_wr && reg_addr == 8'h00) en   <= reg_wdata[3:0];
      if (reg_wr && reg_addr == 8'h08) mask <= reg_wdata[3:0];
      if (reg_wr && reg_addr == 8'h10) emux <= reg_wdata[4*EW-1:0];
      if (reg_wr && reg_addr == 8'h14) prio <= reg_wdata[7:0];
      for (int i = 0; i < 4; i++) begin
        if (reg_wr && reg_addr == 8'(8'h20 + 8*i)) smux[i] <= reg_wdata[MW-1:0];
        if (reg_wr && reg_addr == 8'(8'h24 + 8*i)) sctl[i] <= reg_wdata[CW-1:0];
      end
      raw  <= (raw & ~((reg_wr && reg_addr == 8'h04) ? reg_wdata[3:0] : 4'd0))
            | ((done_ok && cnib[2]) ? (4'd1 << cur) : 4'd0);
      pend <= (pend & en & ~(grant ? (4'd1 << gnt) : 4'd0)) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cur       <= '0;
      step      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_seq   <= '0;
      res_step  <= '0;
    end else begin
      res_valid <= done_ok;
      if (done_ok) begin
        res_data <= conv_data;
        res_seq  <= cur;
        res_step <= step;
      end
      case (st)
        IDLE:  if (gnt_v) begin
                 cur  <= gnt;
                 step <= '0;
                 st   <= START;
               end
        START: st <= WAIT;
        WAIT:  if (conv_done) begin
                 if (last) st <= IDLE;
                 else begin
                   step <= step + 1'b1;
                   st   <= START;
                 end
               end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_start,
  input logic       conv_done,
  input logic       res_valid,
  input logic [3:0] irq,
  input logic [3:0] raw,
  input logic [3:0] en,
  input logic       grant,
  input logic [1:0] gnt,
  input logic [1:0] cur,
  input logic       busy,
  input logic       waiting
);
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_grant_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> en[gnt]);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~raw) == 4'd0);

  assert_raw_from_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~$past(raw)) != 4'd0) |-> res_valid);

  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur));

  assert_result_follows_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && conv_done) |=> res_valid);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .res_valid(res_valid), .irq(irq), .raw(raw), .en(en), .grant(grant),
  .gnt(gnt), .cur(cur), .busy(st != IDLE), .waiting(st == WAIT)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  logic        clk = 0, rst_n = 0, reg_wr = 0, conv_done = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] evt_in = 0;
  logic        conv_start, res_valid;
  logic [3:0]  conv_chan, irq;
  logic [11:0] conv_data = 0, res_data;
  logic [1:0]  res_seq;
  logic [2:0]  res_step;

  int checks = 0, fails = 0, cnt = 0, nlog = 0;
  int lg_chan[64], lg_seq[64], lg_step[64];

  adc_seq_ctrl i_adc_seq_ctrl (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    conv_done = 0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin conv_done = 1; conv_data = {4'hC, 4'h0, conv_chan}; end
    end
    if (conv_start) cnt = 2;
  end

  always @(negedge clk) if (res_valid && nlog < 64) begin
    lg_chan[nlog] = int'(res_data[3:0]);
    lg_seq[nlog]  = int'(res_seq);
    lg_step[nlog] = int'(res_step);
    nlog++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk); evt_in = m;
    @(negedge clk); evt_in = 0;
  endtask

  task automatic drain(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    rd(8'h00, v); chk(v == 0, "R1 enable", v, 0);
    rd(8'h04, v); chk(v == 0, "R1 raw", v, 0);
    rd(8'h08, v); chk(v == 0, "R1 mask", v, 0);
    rd(8'h14, v); chk(v == 32'hE4, "R1 priority", v, 32'hE4);
    chk(irq == 0 && conv_start == 0, "R1 outputs", {irq, conv_start}, 0);
  endtask

  task automatic t_single;
    int v;
    wr(8'h10, 32'h3210);
    wr(8'h20, 32'h0000_0A73);
    wr(8'h24, 32'h0000_0600);
    wr(8'h00, 32'h1);
    nlog = 0;
    pulse(16'h0001);
    drain(60);
    chk(nlog == 3, "R4 step count at END", nlog, 3);
    chk(lg_chan[0] == 3 && lg_chan[1] == 7 && lg_chan[2] == 10, "R4 channel order",
        lg_chan[0]*256 + lg_chan[1]*16 + lg_chan[2], 32'h37A);
    chk(lg_step[0] == 0 && lg_step[2] == 2 && lg_seq[1] == 0, "R9 result tags",
        lg_step[2], 2);
    rd(8'h04, v); chk(v == 1, "R7 raw set by IE step", v, 1);
    chk(irq == 0, "R8 masked off", irq, 0);
    wr(8'h08, 32'h1);
    #1 chk(irq == 4'h1, "R8 irq with mask", irq, 1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk(v == 0, "R7 write-one clear", v, 0);
    chk(irq == 0, "R8 irq after clear", irq, 0);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_noend;
    wr(8'h28, 32'hFEDC_BA98);
    wr(8'h2C, 32'h0);
    wr(8'h00, 32'h3);
    nlog = 0;
    pulse(16'h0002);
    drain(80);
    chk(nlog == 8, "R5 eight conversions", nlog, 8);
    chk(lg_chan[7] == 15 && lg_step[7] == 7 && lg_seq[7] == 1, "R5 last step", lg_step[7], 7);
  endtask

  task automatic t_trigsel;
    wr(8'h10, 32'h3250);
    nlog = 0;
    pulse(16'h0010);
    drain(20);
    chk(nlog == 0, "R10 wrong event ignored", nlog, 0);
    pulse(16'h0020);
    drain(80);
    chk(nlog == 8 && lg_seq[0] == 1, "R10 selected event runs", nlog, 8);
    wr(8'h10, 32'h3210);
  endtask

  task automatic t_disabled;
    int v;
    wr(8'h30, 32'h5);
    wr(8'h34, 32'h6);
    wr(8'h00, 32'hB);
    nlog = 0;
    pulse(16'h0004);
    drain(20);
    chk(nlog == 0, "R2 disabled ignores trigger", nlog, 0);
    wr(8'h00, 32'hF);
    drain(20);
    chk(nlog == 0, "R2 no stale trigger", nlog, 0);
    rd(8'h04, v); chk(v == 0, "R2 raw untouched", v, 0);
  endtask

  task automatic t_prio;
    wr(8'h24, 32'h2);
    wr(8'h2C, 32'h2);
    wr(8'h34, 32'h2);
    wr(8'h3C, 32'h2);
    nlog = 0;
    pulse(16'h0009);
    drain(30);
    chk(nlog == 2 && lg_seq[0] == 0 && lg_seq[1] == 3, "R3 default order", lg_seq[0], 0);
    wr(8'h14, 32'h16);
    nlog = 0;
    pulse(16'h0009);
    drain(30);
    chk(nlog == 2 && lg_seq[0] == 3 && lg_seq[1] == 0, "R3 reprogrammed order", lg_seq[0], 3);
    nlog = 0;
    pulse(16'h0006);
    drain(30);
    chk(nlog == 2 && lg_seq[0] == 1 && lg_seq[1] == 2, "R3 tie to lower index", lg_seq[0], 1);
  endtask

  task automatic t_nopreempt;
    wr(8'h24, 32'h200);
    nlog = 0;
    pulse(16'h0001);
    drain(3);
    pulse(16'h0008);
    drain(60);
    chk(nlog == 4 && lg_seq[0] == 0 && lg_seq[1] == 0 && lg_seq[2] == 0 && lg_seq[3] == 3,
        "R6 run completes first", lg_seq[1]*16 + lg_seq[3], 3);
  endtask

  initial begin
    #200_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_single;
    t_noend;
    t_trigsel;
    t_disabled;
    t_prio;
    t_nopreempt;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule